// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor Core

This block is a small processor built around one accumulator register and a private word-addressed memory that holds both program and data. Every instruction word holds an operation code in its upper bits and a memory address in its lower bits. The core alternates between two phases. In the fetch phase it reads the word at the program counter into an instruction register and advances the counter. In the execute phase it carries out the decoded operation on the accumulator and the addressed memory word.

Three operations are defined: copy a memory word into the accumulator, write the accumulator into a memory word, and add a memory word into the accumulator. Any other code stops the core, which then raises a halted flag. The program counter and accumulator are brought out as debug taps. While reset is held, a preload port writes program and data words into the memory. The memory keeps its contents through reset, so a program can be loaded once and run again.

Top module: `accum_core`

## Requirements
- R1: An instruction word has its opcode in bits 15:12 and its address in bits 11:0. Opcode 1 copies the addressed memory word into the accumulator.
- R2: Opcode 2 writes the accumulator into the addressed memory word and leaves the accumulator unchanged.
- R3: Opcode 5 adds the addressed memory word to the accumulator. The sum wraps modulo 2^16 and no carry is kept.
- R4: Each instruction takes one fetch cycle and then one execute cycle. The program counter rises by one on the fetch edge and the accumulator can change only on the execute edge.
- R5: Opcode 0, and every opcode other than 1, 2 and 5, sets the halted flag in its execute cycle. From then until reset the flag stays set and the program counter and accumulator stay frozen.
- R6: A synchronous reset clears the program counter, the accumulator, the phase and the halted flag. Memory contents survive reset.
- R7: The preload port writes the memory only while reset is asserted. A store whose execute cycle coincides with reset does not write the memory.
- R8: The program "load 940, add 941, store 941" leaves the sum of the two words in word 941.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables preload |
| ld_we | input | 1 | Preload write enable, honoured only during reset |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word value |
| halted | output | 1 | Core has stopped on an undefined or zero opcode |
| pc_tap | output | 12 | Current program counter |
| acc_tap | output | 16 | Current accumulator |

## Verification
Reset and a store execute can fall in the same clock cycle, and the design gives reset priority over the core's own memory write. The bench starts a program that loads a word and then stores it over a second word. It asserts reset just before the edge on which the store executes. A follow-up program reads the second word back into the accumulator, and the check passes only if that word still holds its preloaded value.

// File: rtl/accum_core.sv
module accum_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_tap,
  output logic [DATA_W-1:0] acc_tap
);
  localparam int OP_W  = DATA_W - ADDR_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(2);
  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(5);

  typedef enum logic {PH_FETCH, PH_EXEC} phase_t;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ir;
  phase_t            phase;

  wire [OP_W-1:0]   op      = ir[DATA_W-1:ADDR_W];
  wire [ADDR_W-1:0] opnd_a  = ir[ADDR_W-1:0];
  wire [DATA_W-1:0] opnd    = mem[opnd_a];
  wire              exec_ok = !rst && !halted && phase == PH_EXEC;
  wire              st_en   = exec_ok && op == OP_STORE;

  wire              mem_we = rst ? ld_we   : st_en;
  wire [ADDR_W-1:0] mem_wa = rst ? ld_addr : opnd_a;
  wire [DATA_W-1:0] mem_wd = rst ? ld_data : acc;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      acc    <= '0;
      ir     <= '0;
      phase  <= PH_FETCH;
      halted <= 1'b0;
    end else if (!halted) begin
      if (phase == PH_FETCH) begin
        ir    <= mem[pc];
        pc    <= pc + 1'b1;
        phase <= PH_EXEC;
      end else begin
        phase <= PH_FETCH;
        case (op)
          OP_LOAD:  acc <= opnd;
          OP_ADD:   acc <= acc + opnd;
          OP_STORE: ;
          default:  halted <= 1'b1;
        endcase
      end
    end
  end

  assign pc_tap  = pc;
  assign acc_tap = acc;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!halted && phase == PH_FETCH) |=> pc == $past(pc) + 1'b1); // R4
  AST_ACC_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> $stable(acc)); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc) && $stable(acc))); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !halted && phase == PH_FETCH)); // R6
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    st_en |=> $stable(acc)); // R2
endmodule

// File: tb/sim_accum_core.sv
module sim_accum_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        halted;
  logic [11:0] pc_tap;
  logic [15:0] acc_tap;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  accum_core u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .pc_tap(pc_tap), .acc_tap(acc_tap)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // operand a, operand b, expected wrapped sum
  localparam logic [15:0] VEC [4][3] = '{
    '{16'h0003, 16'h0004, 16'h0007},
    '{16'h1234, 16'h0F0F, 16'h2143},
    '{16'hFFFF, 16'h0002, 16'h0001},
    '{16'h8000, 16'h8000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    rst = 1'b1; ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input int limit);
    for (int i = 0; i < limit && !halted; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset pc", pc_tap, 0);
    chk("R6 reset acc", acc_tap, 0);
    chk("R6 reset halted", halted, 0);

    // R8 / R1 / R2 / R3: table walk
    for (int v = 0; v < 4; v++) begin
      preload(12'd0, 16'h13AC);   // load 940
      preload(12'd1, 16'h53AD);   // add 941
      preload(12'd2, 16'h23AD);   // store 941
      preload(12'd3, 16'h13AC);   // load 940
      preload(12'd4, 16'h13AD);   // load 941
      preload(12'd5, 16'h0000);   // halt
      preload(12'd940, VEC[v][0]);
      preload(12'd941, VEC[v][1]);
      release_rst();
      wait_halt(100);
      chk("R8 stored sum read back", acc_tap, VEC[v][2]);
      chk("R5 halt pc", pc_tap, 6);
      chk("R5 halted set", halted, 1);
    end

    // R4 / R1: phase timing, R3 add
    preload(12'd0, 16'h1010);     // load 16
    preload(12'd1, 16'h5011);     // add 17
    preload(12'd2, 16'h2012);     // store 18 (acc must stay)
    preload(12'd3, 16'h3000);     // undefined opcode 3
    preload(12'd16, 16'h00A5);
    preload(12'd17, 16'h0100);
    release_rst();
    @(negedge clk);
    chk("R4 pc after fetch", pc_tap, 1);
    chk("R4 acc unchanged at fetch", acc_tap, 0);
    @(negedge clk);
    chk("R1 acc after load execute", acc_tap, 16'h00A5);
    chk("R4 pc held in execute", pc_tap, 1);
    @(negedge clk);
    chk("R4 acc held during fetch", acc_tap, 16'h00A5);
    @(negedge clk);
    chk("R3 acc after add", acc_tap, 16'h01A5);
    @(negedge clk);
    @(negedge clk);
    chk("R2 acc unchanged by store", acc_tap, 16'h01A5);
    chk("R5 not halted before opcode 3", halted, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 undefined opcode 3 halts", halted, 1);
    repeat (10) @(negedge clk);
    chk("R5 pc frozen", pc_tap, 4);
    chk("R5 acc frozen", acc_tap, 16'h01A5);
    chk("R5 halted sticky", halted, 1);

    // R2: stored word observed by reloading
    preload(12'd0, 16'h1012);     // load 18
    preload(12'd1, 16'hF000);     // undefined opcode 15
    release_rst();
    wait_halt(50);
    chk("R2 store wrote memory", acc_tap, 16'h01A5);
    chk("R5 opcode 15 halts at pc 2", pc_tap, 2);

    // R7 / R6: reset coinciding with store execute
    preload(12'd0, 16'h1014);     // load 20
    preload(12'd1, 16'h2015);     // store 21
    preload(12'd2, 16'h0000);
    preload(12'd20, 16'h1234);
    preload(12'd21, 16'hAAAA);
    release_rst();
    repeat (3) @(negedge clk);    // fetch, execute load, fetch store
    rst = 1'b1;                   // reset lands on store execute edge
    @(negedge clk);
    chk("R6 reset clears pc", pc_tap, 0);
    chk("R6 reset clears acc", acc_tap, 0);
    preload(12'd0, 16'h1015);     // load 21
    preload(12'd1, 16'h0000);
    release_rst();
    wait_halt(50);
    chk("R7 store suppressed by reset", acc_tap, 16'hAAAA);

    // R7: preload ignored while running
    preload(12'd0, 16'h1016);     // load 22
    preload(12'd1, 16'h0000);
    preload(12'd22, 16'h0055);
    release_rst();
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 12'd22; ld_data = 16'hBEEF;
    @(negedge clk);
    ld_we = 1'b0;
    wait_halt(50);
    chk("R7 preload outside reset ignored", acc_tap, 16'h0055);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule